// File: doc/BRIEF.md
# Sector Access Rights Gate

This block decides whether one memory operation on one block of a sector may proceed. Each sector of a contactless memory card keeps a trailer block whose configuration bytes hold a three-bit rights code for each of its four blocks. Every code is held twice, once as written and once complemented. For each request the gate unpacks the codes and checks the two copies against each other. It then looks up the rights for the requested block, operation and authentication key, and answers grant or deny one clock later.

A copy mismatch on any access is a format violation. The gate reports it and latches a lock flag for that sector. From then on, every request for that sector is refused until reset. The gate also reports when the trailer's code makes key B readable. In that case an authentication made with key B cannot be trusted, and all access under it is refused. For reads of the key fields, the gate tells the data path whether the returned bytes must be replaced by zeros. Key storage, authentication and the memory array sit outside this block.

Top module: `sector_access_gate`

## Requirements
- R1: Byte 6 holds the complemented C2 nibble in bits 7:4 and the complemented C1 nibble in bits 3:0. Byte 7 holds C1 in bits 7:4 and the complemented C3 nibble in bits 3:0. Byte 8 holds C3 in bits 7:4 and C2 in bits 3:0. Bit i of each nibble belongs to block i. If any true bit differs from the complement of its paired bit, the response shows `rsp_fmt_err`=1 and `rsp_grant`=0.
- R2: A format violation sets a lock for the sector in the request. Once set, every later request to that sector is denied with `rsp_locked`=1, even when its bytes are correct. Other sectors are unaffected. Only reset clears a lock.
- R3: For blocks 0 to 2, the code {C1,C2,C3} grants rights as follows, with A|B meaning either key:
  - 000: read, write, increment and decrement/transfer/restore, each with A|B.
  - 010: read with A|B only.
  - 100: read with A|B; write with B.
  - 110: read and decrement/transfer/restore with A|B; write and increment with B.
  - 001: read and decrement/transfer/restore with A|B.
  - 011: read and write with B.
  - 101: read with B.
  - 111: nothing.
- R4: For block 3, the operation applies to the field chosen by `fld_i`. Field 0 is key A, field 1 is the access bytes together with user byte 9, field 2 is key B, and field 3 is always denied. Trailer codes grant these rights, listed as key-A write / access read / access write / key-B read / key-B write:
  - 000: A / A / never / A / A.
  - 010: never / A / never / A / never.
  - 100: B / A|B / never / never / B.
  - 110: never / A|B / never / never / never.
  - 001: A / A / A / A / A.
  - 011: B / A|B / B / never / B.
  - 101: never / A|B / B / never / never.
  - 111: never / A|B / never / never / never.
- R5: `rsp_kb_readable` is 1 exactly when the trailer code (block 3) is 000, 010 or 001. In that case any request made with key B (`key_b_i`=1) is denied.
- R6: Reading key A is never granted. For a read of block 3, `rsp_blank`=1 for field 0, and for field 2 when key B is not readable. Otherwise `rsp_blank`=0.
- R7: Block 0 of sector 0 grants only reads (op 0). Write, increment and decrement/transfer/restore are denied whatever its code.
- R8: Increment (op 2) and decrement/transfer/restore (op 3) on block 3 are always denied. Op codes are: 0 read, 1 write, 2 increment, 3 decrement/transfer/restore.
- R9: A request sampled with `chk_valid`=1 on a rising edge is answered on the next edge, with `rsp_valid`=1. Without a request, `rsp_valid` and `rsp_grant` are 0 and no lock changes. After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chk_valid | input | 1 | Request present this cycle |
| sector_i | input | SECT_W | Sector of the request |
| blk_i | input | 2 | Block within the sector, 3 is the trailer |
| op_i | input | 2 | Operation: 0 read, 1 write, 2 increment, 3 decrement/transfer/restore |
| fld_i | input | 2 | Trailer field: 0 key A, 1 access bytes, 2 key B, 3 reserved |
| key_b_i | input | 1 | 1 when the session was authenticated with key B |
| acc_b6_i | input | 8 | Trailer configuration byte 6 |
| acc_b7_i | input | 8 | Trailer configuration byte 7 |
| acc_b8_i | input | 8 | Trailer configuration byte 8 |
| rsp_valid | output | 1 | Response present |
| rsp_grant | output | 1 | Operation allowed |
| rsp_fmt_err | output | 1 | Copy mismatch seen in this request |
| rsp_locked | output | 1 | Sector is locked after this request |
| rsp_kb_readable | output | 1 | Trailer code makes key B readable |
| rsp_blank | output | 1 | Key bytes must be returned as zeros |

## Verification
The bench builds the gate with NUM_SECTORS set to 8. That is small enough for a random run with occasional corrupted copies to lock several sectors while others stay clean, so locking and sector independence get exercised together. Random codes for all four blocks, mixed with random operations, fields and keys, cover every row of both rights tables under both keys. Directed cases pin down the manufacturer block, key blanking, key-B disqualification and the clearing of locks by reset.

// File: rtl/sag_pkg.sv
// Shared types for the sector access gate: operation and field codes,
// the four-valued key permission, and the helper that applies it.
package sag_pkg;

    localparam int NUM_BLKS = 4;
    localparam int CODE_W   = 3;

    typedef enum logic [1:0] {
        OP_RD  = 2'd0,
        OP_WR  = 2'd1,
        OP_INC = 2'd2,
        OP_DTR = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        FLD_KA  = 2'd0,
        FLD_ACC = 2'd1,
        FLD_KB  = 2'd2,
        FLD_RSV = 2'd3
    } fld_e;

    typedef enum logic [1:0] {
        P_NONE = 2'd0,
        P_A    = 2'd1,
        P_B    = 2'd2,
        P_AB   = 2'd3
    } perm_e;

    // Return whether the key in use satisfies a permission.
    function automatic logic key_fits(perm_e p, logic key_b);
        return key_b ? p[1] : p[0];
    endfunction

endpackage

// File: rtl/sag_unpack.sv
// Splits trailer bytes 6..8 into one rights code per block and flags any
// disagreement between a true bit and its complemented copy.
// Assumes bit i of each nibble belongs to block i.
module sag_unpack
    import sag_pkg::*;
(
    input  logic [7:0]                       acc6,
    input  logic [7:0]                       acc7,
    input  logic [7:0]                       acc8,
    output logic [NUM_BLKS-1:0][CODE_W-1:0]  codes,
    output logic                             fmt_bad
);

    logic [NUM_BLKS-1:0] bad_blk;

    for (genvar b = 0; b < NUM_BLKS; b++) begin : g_blk
        // Gather {C1,C2,C3} for block b from the true copies.
        assign codes[b] = {acc7[4+b], acc8[b], acc8[4+b]};
        // Any true bit equal to its complement slot is a violation.
        assign bad_blk[b] = (acc7[4+b] == acc6[b])   |
                            (acc8[b]   == acc6[4+b]) |
                            (acc8[4+b] == acc7[b]);
    end

    assign fmt_bad = |bad_blk;

endmodule

// File: rtl/sag_data_rule.sv
// Rights lookup for an ordinary block (0..2) of a sector.
// Assumes the code is {C1,C2,C3}; combinational only.
module sag_data_rule
    import sag_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    input  op_e               op,
    input  logic              key_b,
    output logic              ok
);

    perm_e p_rd, p_wr, p_inc, p_dtr;
    perm_e p_sel;

    // Per-code rights for each of the four operations.
    always_comb begin
        p_rd = P_NONE; p_wr = P_NONE; p_inc = P_NONE; p_dtr = P_NONE;
        case (code)
            3'b000: begin p_rd = P_AB; p_wr = P_AB; p_inc = P_AB; p_dtr = P_AB; end
            3'b010: begin p_rd = P_AB; end
            3'b100: begin p_rd = P_AB; p_wr = P_B; end
            3'b110: begin p_rd = P_AB; p_wr = P_B; p_inc = P_B; p_dtr = P_AB; end
            3'b001: begin p_rd = P_AB; p_dtr = P_AB; end
            3'b011: begin p_rd = P_B;  p_wr = P_B; end
            3'b101: begin p_rd = P_B; end
            default: ;
        endcase
    end

    // Pick the right for the requested operation.
    always_comb begin
        case (op)
            OP_RD:   p_sel = p_rd;
            OP_WR:   p_sel = p_wr;
            OP_INC:  p_sel = p_inc;
            default: p_sel = p_dtr;
        endcase
    end

    assign ok = key_fits(p_sel, key_b);

endmodule

// File: rtl/sag_trailer_rule.sv
// Rights lookup for the trailer block, per field, plus the key-B
// readability flag. Key A is never readable; value operations never apply.
module sag_trailer_rule
    import sag_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    input  op_e               op,
    input  fld_e              fld,
    input  logic              key_b,
    output logic              ok,
    output logic              kb_visible
);

    perm_e ka_wr, ac_rd, ac_wr, kb_rd, kb_wr;
    perm_e p_sel;

    // Per-code rights for the five trailer field accesses.
    always_comb begin
        ka_wr = P_NONE; ac_rd = P_AB; ac_wr = P_NONE; kb_rd = P_NONE; kb_wr = P_NONE;
        case (code)
            3'b000: begin ka_wr = P_A; ac_rd = P_A; kb_rd = P_A; kb_wr = P_A; end
            3'b010: begin ac_rd = P_A; kb_rd = P_A; end
            3'b100: begin ka_wr = P_B; kb_wr = P_B; end
            3'b001: begin ka_wr = P_A; ac_rd = P_A; ac_wr = P_A; kb_rd = P_A; kb_wr = P_A; end
            3'b011: begin ka_wr = P_B; ac_wr = P_B; kb_wr = P_B; end
            3'b101: begin ac_wr = P_B; end
            default: ;
        endcase
    end

    // Select by field and read/write; other operations get nothing.
    always_comb begin
        p_sel = P_NONE;
        if (op == OP_RD) begin
            case (fld)
                FLD_ACC: p_sel = ac_rd;
                FLD_KB:  p_sel = kb_rd;
                default: p_sel = P_NONE;
            endcase
        end else if (op == OP_WR) begin
            case (fld)
                FLD_KA:  p_sel = ka_wr;
                FLD_ACC: p_sel = ac_wr;
                FLD_KB:  p_sel = kb_wr;
                default: p_sel = P_NONE;
            endcase
        end
    end

    assign ok         = key_fits(p_sel, key_b);
    assign kb_visible = (code == 3'b000) | (code == 3'b010) | (code == 3'b001);

endmodule

// File: rtl/sector_access_gate.sv
// Top of the sector access gate. Combines the unpacked codes, the block
// and trailer rules, the manufacturer-block and key-B restrictions and a
// sticky per-sector lock, and registers a one-cycle-late response.
// Assumes the caller presents the trailer bytes of the addressed sector.
module sector_access_gate
    import sag_pkg::*;
#(
    parameter  int NUM_SECTORS = 16,
    localparam int SECT_W      = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chk_valid,
    input  logic [SECT_W-1:0] sector_i,
    input  logic [1:0]        blk_i,
    input  logic [1:0]        op_i,
    input  logic [1:0]        fld_i,
    input  logic              key_b_i,
    input  logic [7:0]        acc_b6_i,
    input  logic [7:0]        acc_b7_i,
    input  logic [7:0]        acc_b8_i,
    output logic              rsp_valid,
    output logic              rsp_grant,
    output logic              rsp_fmt_err,
    output logic              rsp_locked,
    output logic              rsp_kb_readable,
    output logic              rsp_blank
);

    localparam logic [1:0] TRL_BLK = 2'(NUM_BLKS - 1);

    logic [NUM_BLKS-1:0][CODE_W-1:0] blk_code;
    logic                            fmt_bad;
    logic                            data_ok, trl_ok, kb_vis;
    logic [NUM_SECTORS-1:0]          lock_q;
    op_e                             op;
    fld_e                            fld;
    logic                            is_trl, is_manuf, cur_lock;
    logic                            perm_ok, grant_d, blank_d;

    assign op  = op_e'(op_i);
    assign fld = fld_e'(fld_i);

    sag_unpack u_unpack (
        .acc6    (acc_b6_i),
        .acc7    (acc_b7_i),
        .acc8    (acc_b8_i),
        .codes   (blk_code),
        .fmt_bad (fmt_bad)
    );

    sag_data_rule u_data (
        .code  (blk_code[blk_i]),
        .op    (op),
        .key_b (key_b_i),
        .ok    (data_ok)
    );

    sag_trailer_rule u_trl (
        .code       (blk_code[TRL_BLK]),
        .op         (op),
        .fld        (fld),
        .key_b      (key_b_i),
        .ok         (trl_ok),
        .kb_visible (kb_vis)
    );

    assign is_trl   = (blk_i == TRL_BLK);
    assign is_manuf = (sector_i == '0) && (blk_i == 2'd0);
    assign cur_lock = lock_q[sector_i];

    // Combine the rule result with every sector-wide restriction.
    always_comb begin
        perm_ok = is_trl ? trl_ok : data_ok;
        if (is_manuf && op != OP_RD) perm_ok = 1'b0;
        if (key_b_i && kb_vis)       perm_ok = 1'b0;
        grant_d = chk_valid && perm_ok && !fmt_bad && !cur_lock;
        blank_d = is_trl && (op == OP_RD) &&
                  ((fld == FLD_KA) || (fld == FLD_KB && !kb_vis));
    end

    for (genvar s = 0; s < NUM_SECTORS; s++) begin : g_lock
        // Sticky lock for sector s, set by a violation, cleared by reset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                lock_q[s] <= 1'b0;
            else if (chk_valid && fmt_bad && (sector_i == SECT_W'(s)))
                lock_q[s] <= 1'b1;
        end
    end

    // Register the response one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid       <= 1'b0;
            rsp_grant       <= 1'b0;
            rsp_fmt_err     <= 1'b0;
            rsp_locked      <= 1'b0;
            rsp_kb_readable <= 1'b0;
            rsp_blank       <= 1'b0;
        end else begin
            rsp_valid       <= chk_valid;
            rsp_grant       <= grant_d;
            rsp_fmt_err     <= chk_valid && fmt_bad;
            rsp_locked      <= chk_valid && (cur_lock || fmt_bad);
            rsp_kb_readable <= chk_valid && kb_vis;
            rsp_blank       <= chk_valid && blank_d;
        end
    end

endmodule

// File: rtl/sag_checker.sv
// Temporal checks for the sector access gate, attached by bind.
// Relates each request to the response seen on the following edge.
module sag_checker #(
    parameter  int NUM_SECTORS = 16,
    localparam int SECT_W      = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   chk_valid,
    input logic [SECT_W-1:0]      sector_i,
    input logic [1:0]             blk_i,
    input logic [1:0]             op_i,
    input logic [1:0]             fld_i,
    input logic                   key_b_i,
    input logic [7:0]             acc_b6_i,
    input logic [7:0]             acc_b7_i,
    input logic [7:0]             acc_b8_i,
    input logic [NUM_SECTORS-1:0] lock_q,
    input logic                   rsp_valid,
    input logic                   rsp_grant,
    input logic                   rsp_fmt_err,
    input logic                   rsp_blank
);

    logic copies_differ;
    logic kb_code;

    assign copies_differ = (acc_b7_i[7:4] != ~acc_b6_i[3:0]) ||
                           (acc_b8_i[3:0] != ~acc_b6_i[7:4]) ||
                           (acc_b8_i[7:4] != ~acc_b7_i[3:0]);
    assign kb_code = ({acc_b7_i[7], acc_b8_i[3], acc_b8_i[7]} == 3'b000) ||
                     ({acc_b7_i[7], acc_b8_i[3], acc_b8_i[7]} == 3'b010) ||
                     ({acc_b7_i[7], acc_b8_i[3], acc_b8_i[7]} == 3'b001);

    assert_rsp_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid == $past(chk_valid));

    assert_idle_no_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !rsp_grant);

    assert_lock_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q & $past(lock_q)) == $past(lock_q));

    assert_mismatch_denied_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(chk_valid && copies_differ) |-> (rsp_fmt_err && !rsp_grant));

    assert_keya_hidden_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(chk_valid && blk_i == 2'd3 && op_i == 2'd0 && fld_i == 2'd0)
        |-> (!rsp_grant && rsp_blank));

    assert_manuf_readonly_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(chk_valid && sector_i == '0 && blk_i == 2'd0 && op_i != 2'd0)
        |-> !rsp_grant);

    assert_kb_auth_refused_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(chk_valid && key_b_i && kb_code) |-> !rsp_grant);

    assert_trl_no_value_ops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(chk_valid && blk_i == 2'd3 && op_i[1]) |-> !rsp_grant);

endmodule

bind sector_access_gate sag_checker #(.NUM_SECTORS(NUM_SECTORS)) u_sag_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .chk_valid (chk_valid),
    .sector_i  (sector_i),
    .blk_i     (blk_i),
    .op_i      (op_i),
    .fld_i     (fld_i),
    .key_b_i   (key_b_i),
    .acc_b6_i  (acc_b6_i),
    .acc_b7_i  (acc_b7_i),
    .acc_b8_i  (acc_b8_i),
    .lock_q    (lock_q),
    .rsp_valid (rsp_valid),
    .rsp_grant (rsp_grant),
    .rsp_fmt_err (rsp_fmt_err),
    .rsp_blank (rsp_blank)
);

// File: tb/sector_access_gate_tb_top.sv
// Self-checking bench: seeded random requests plus directed corner cases,
// compared against a model built from the written requirements.
module sector_access_gate_tb_top;

    localparam int NS = 8;
    localparam int SW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          chk_valid = 1'b0;
    logic [SW-1:0] sector_i = '0;
    logic [1:0]    blk_i = '0, op_i = '0, fld_i = '0;
    logic          key_b_i = 1'b0;
    logic [7:0]    b6 = 8'h0, b7 = 8'h0, b8 = 8'h0;
    logic          rsp_valid, rsp_grant, rsp_fmt_err, rsp_locked, rsp_kb_readable, rsp_blank;

    int  n_run = 0;
    int  n_fail = 0;
    bit  exp_lock [NS];
    bit  done = 1'b0;

    always #5 clk = ~clk;

    sector_access_gate #(.NUM_SECTORS(NS)) dut_i (
        .clk (clk), .rst_n (rst_n), .chk_valid (chk_valid),
        .sector_i (sector_i), .blk_i (blk_i), .op_i (op_i), .fld_i (fld_i),
        .key_b_i (key_b_i), .acc_b6_i (b6), .acc_b7_i (b7), .acc_b8_i (b8),
        .rsp_valid (rsp_valid), .rsp_grant (rsp_grant), .rsp_fmt_err (rsp_fmt_err),
        .rsp_locked (rsp_locked), .rsp_kb_readable (rsp_kb_readable),
        .rsp_blank (rsp_blank)
    );

    // Rights word for ordinary blocks: {read,write,inc,dtr}, 2 bits each, bit0=A, bit1=B.
    function automatic logic [7:0] data_word(logic [2:0] c);
        case (c)
            3'b000: return 8'b11_11_11_11;
            3'b010: return 8'b11_00_00_00;
            3'b100: return 8'b11_10_00_00;
            3'b110: return 8'b11_10_10_11;
            3'b001: return 8'b11_00_00_11;
            3'b011: return 8'b10_10_00_00;
            3'b101: return 8'b10_00_00_00;
            default: return 8'b0;
        endcase
    endfunction

    // Trailer rights word: {keyA wr, acc rd, acc wr, keyB rd, keyB wr}.
    function automatic logic [9:0] trl_word(logic [2:0] c);
        case (c)
            3'b000: return 10'b01_01_00_01_01;
            3'b010: return 10'b00_01_00_01_00;
            3'b100: return 10'b10_11_00_00_10;
            3'b110: return 10'b00_11_00_00_00;
            3'b001: return 10'b01_01_01_01_01;
            3'b011: return 10'b10_11_10_00_10;
            3'b101: return 10'b00_11_10_00_00;
            default: return 10'b00_11_00_00_00;
        endcase
    endfunction

    // Build correctly packed bytes from four codes.
    task automatic pack(input logic [2:0] c0, input logic [2:0] c1,
                        input logic [2:0] c2, input logic [2:0] c3);
        logic [3:0] n1, n2, n3;
        n1 = {c3[2], c2[2], c1[2], c0[2]};
        n2 = {c3[1], c2[1], c1[1], c0[1]};
        n3 = {c3[0], c2[0], c1[0], c0[0]};
        b6 = {~n2, ~n1};
        b7 = {n1, ~n3};
        b8 = {n3, n2};
    endtask

    task automatic finish_up();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    task automatic chk(string req, string what, logic act, logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    // Issue one request, then check every response output one edge later.
    task automatic req(input logic [SW-1:0] s, input logic [1:0] b, input logic [1:0] o,
                       input logic [1:0] f, input logic kb, input string force_tag);
        logic       mism, kbr, lk, g, bl;
        logic [2:0] cd, ct;
        logic [1:0] r;
        string      tag;
        @(negedge clk);
        sector_i = s; blk_i = b; op_i = o; fld_i = f; key_b_i = kb; chk_valid = 1'b1;
        mism = (b7[7:4] != ~b6[3:0]) || (b8[3:0] != ~b6[7:4]) || (b8[7:4] != ~b7[3:0]);
        cd   = {b7[4+b], b8[b], b8[4+b]};
        ct   = {b7[7], b8[3], b8[7]};
        kbr  = (ct == 3'b000) || (ct == 3'b010) || (ct == 3'b001);
        if (b == 2'd3) begin
            r = 2'b00;
            if (o == 2'd0 && f == 2'd1) r = trl_word(ct)[7:6];
            if (o == 2'd0 && f == 2'd2) r = trl_word(ct)[3:2];
            if (o == 2'd1 && f == 2'd0) r = trl_word(ct)[9:8];
            if (o == 2'd1 && f == 2'd1) r = trl_word(ct)[5:4];
            if (o == 2'd1 && f == 2'd2) r = trl_word(ct)[1:0];
            tag = (o[1]) ? "R8" : "R4";
        end else begin
            r = data_word(cd)[7 - 2*o -: 2];
            tag = "R3";
        end
        g = kb ? r[1] : r[0];
        if (s == 0 && b == 0 && o != 0) begin g = 1'b0; tag = "R7"; end
        if (kb && kbr) begin g = 1'b0; tag = "R5"; end
        lk = exp_lock[s] || mism;
        if (exp_lock[s]) begin g = 1'b0; tag = "R2"; end
        if (mism) begin g = 1'b0; tag = "R1"; end
        bl = (b == 2'd3) && (o == 2'd0) && ((f == 2'd0) || (f == 2'd2 && !kbr));
        if (force_tag != "") tag = force_tag;
        @(posedge clk);
        @(negedge clk);
        chk_valid = 1'b0;
        exp_lock[s] = lk;
        chk("R9", "rsp_valid", rsp_valid, 1'b1);
        chk(tag, "rsp_grant", rsp_grant, g);
        chk("R1", "rsp_fmt_err", rsp_fmt_err, mism);
        chk("R2", "rsp_locked", rsp_locked, lk);
        chk("R5", "rsp_kb_readable", rsp_kb_readable, kbr);
        chk("R6", "rsp_blank", rsp_blank, bl);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; chk_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        foreach (exp_lock[i]) exp_lock[i] = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #1ms;
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL R9 watchdog: actual hung expected finished");
            finish_up();
        end
    end

    initial begin
        void'($urandom(32'h1234_5678));
        foreach (exp_lock[i]) exp_lock[i] = 1'b0;
        repeat (3) @(negedge clk);
        // R9: reset state of every output.
        chk("R9", "reset rsp_valid", rsp_valid, 1'b0);
        chk("R9", "reset rsp_grant", rsp_grant, 1'b0);
        chk("R2", "reset rsp_locked", rsp_locked, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R9", "idle rsp_valid", rsp_valid, 1'b0);
        chk("R9", "idle rsp_grant", rsp_grant, 1'b0);

        // R7: manufacturer block is read-only even with an open code.
        pack(3'b000, 3'b000, 3'b000, 3'b001);
        req(0, 0, 2'd1, 2'd0, 1'b0, "R7");
        req(0, 0, 2'd0, 2'd0, 1'b0, "R7");
        req(1, 0, 2'd1, 2'd0, 1'b0, "R3");
        // R5: trailer 001 makes key B readable, so key B is refused.
        req(1, 1, 2'd0, 2'd0, 1'b1, "R5");
        // R6: key A read denied and blanked; key B read open under 001.
        req(1, 3, 2'd0, 2'd0, 1'b0, "R6");
        req(1, 3, 2'd0, 2'd2, 1'b0, "R6");
        // R6: key B not readable under 011, read blanked and denied.
        pack(3'b000, 3'b000, 3'b000, 3'b011);
        req(2, 3, 2'd0, 2'd2, 1'b0, "R6");
        req(2, 3, 2'd1, 2'd1, 1'b1, "R4");
        // R8: value operations on the trailer are refused.
        pack(3'b000, 3'b000, 3'b000, 3'b001);
        req(2, 3, 2'd2, 2'd1, 1'b0, "R8");
        req(2, 3, 2'd3, 2'd1, 1'b0, "R8");
        // R3: value block 110 under key A and key B.
        pack(3'b110, 3'b111, 3'b001, 3'b011);
        req(3, 0, 2'd2, 2'd0, 1'b0, "R3");
        req(3, 0, 2'd2, 2'd0, 1'b1, "R3");
        req(3, 1, 2'd0, 2'd0, 1'b1, "R3");
        req(3, 2, 2'd3, 2'd0, 1'b0, "R3");
        // R1/R2: a corrupted copy locks sector 5 only.
        pack(3'b000, 3'b000, 3'b000, 3'b011);
        b6[2] = ~b6[2];
        req(5, 0, 2'd0, 2'd0, 1'b0, "R1");
        pack(3'b000, 3'b000, 3'b000, 3'b011);
        req(5, 0, 2'd0, 2'd0, 1'b0, "R2");
        req(6, 0, 2'd0, 2'd0, 1'b0, "R2");
        // R2: reset clears the lock.
        do_reset();
        req(5, 0, 2'd0, 2'd0, 1'b0, "R2");

        // Random requests with correct copies.
        for (int i = 0; i < 3000; i++) begin
            pack(3'($urandom), 3'($urandom), 3'($urandom), 3'($urandom));
            req(SW'($urandom), 2'($urandom), 2'($urandom), 2'($urandom), 1'($urandom), "");
        end
        // Random requests with occasional corrupted copies.
        for (int i = 0; i < 800; i++) begin
            pack(3'($urandom), 3'($urandom), 3'($urandom), 3'($urandom));
            if ($urandom % 40 == 0) begin
                int bitn = $urandom % 24;
                if (bitn < 8) b6[bitn] = ~b6[bitn];
                else if (bitn < 16) b7[bitn-8] = ~b7[bitn-8];
                else b8[bitn-16] = ~b8[bitn-16];
            end
            req(SW'($urandom), 2'($urandom), 2'($urandom), 2'($urandom), 1'($urandom), "");
        end
        done = 1'b1;
        finish_up();
    end

endmodule